// File: doc/BRIEF.md
# Interrupt Flag and Enable Unit

This unit keeps the interrupt control and status byte of a real-time clock. It latches two sticky event flags: one for an alarm match and one for the end of a countdown. It stores an enable for each flag and a mode bit that controls how the countdown raises the interrupt line. The alarm comparator and the countdown timer each deliver a one-cycle event strobe. The countdown's pulse generator also supplies a separate pulse request, which is used when the pulse mode is selected.

A host reaches the byte through a simple write strobe with data and a read bus that always shows the current contents. The enables and the mode bit take the written value. Each flag is instead ANDed with its written bit. A host can therefore write 0 to the flag it has serviced and 1 to the other flag, and clearing one flag never removes the other. The interrupt line is open-drain and active low. It is modelled as an output enable plus a data value that is fixed at 0.

Top module: `irq_flag_unit`

## Requirements
- R1: After a synchronous reset, all five stored bits are 0, `rd_data` reads 0x00 and `irq_oe` is 0.
- R2: An `alarm_evt` strobe sets the alarm flag (read bit 3) at the next clock edge. With no clearing write, the flag then stays 1.
- R3: A `timer_evt` strobe sets the timer flag (read bit 2) at the next clock edge. With no clearing write, the flag then stays 1.
- R4: On a write, each flag becomes its old value AND its written bit (bit 3 for alarm, bit 2 for timer). Writing 1 leaves a flag unchanged and writing 0 clears it.
- R5: A write loads the mode bit from bit 4, the alarm enable from bit 1 and the timer enable from bit 0. Read bits 7..5 are always 0, whatever was written.
- R6: If a set strobe and a write clearing the same flag arrive in the same cycle, the flag ends at 1.
- R7: With mode bit 0 (level mode), `irq_oe` = (alarm flag AND alarm enable) OR (timer flag AND timer enable), with no added delay.
- R8: With mode bit 1 (pulse mode), the timer term is `timer_pulse` AND timer enable, and the timer flag no longer drives the line.
- R9: In pulse mode, an alarm flag with its enable set keeps `irq_oe` at 1 on every cycle, whatever the value of `timer_pulse`.
- R10: With both enables 0, `irq_oe` is 0. `irq_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Host write strobe for the control byte |
| wr_data | input | 8 | Host write data |
| rd_data | output | 8 | Current contents of the control byte |
| alarm_evt | input | 1 | One-cycle alarm match strobe |
| timer_evt | input | 1 | One-cycle countdown expiry strobe |
| timer_pulse | input | 1 | Pulse request from the countdown pulse generator |
| irq_oe | output | 1 | Interrupt pin drive enable (1 = pulled low) |
| irq_o | output | 1 | Interrupt pin data value, always 0 |

## Verification
The assertions assume that the event strobes and write data are known (not X) at every clock edge once reset is released. They also assume that `timer_pulse` is settled before the edge at which the line is sampled. Beyond that they need no particular spacing of events: strobes may repeat on back-to-back cycles and may meet a write in the same cycle. To keep within these assumptions, the stimulus changes every input only on the falling clock edge. It holds each input steady through the following rising edge. Its random phase covers coincident set-and-clear cycles and writes that also carry 1s in the unused bits.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;

    localparam int REG_W     = 8;
    localparam int NUM_FLAGS = 2;

    // Bit positions inside the host byte; the host decodes these.
    localparam int TIE_BIT  = 0;
    localparam int AIE_BIT  = 1;
    localparam int TF_BIT   = 2;
    localparam int AF_BIT   = 3;
    localparam int MODE_BIT = 4;
    localparam int USED_W   = MODE_BIT + 1;

    // Index of each flag in the flag vector.
    localparam int FLAG_TIMER = 0;
    localparam int FLAG_ALARM = 1;

    typedef enum logic {
        TMR_LEVEL = 1'b0,
        TMR_PULSE = 1'b1
    } tmr_mode_e;

    typedef struct packed {
        tmr_mode_e mode;
        logic      alarm_flag;
        logic      timer_flag;
        logic      alarm_en;
        logic      timer_en;
    } irq_state_t;

    typedef struct packed {
        logic alarm_term;
        logic timer_term;
    } irq_terms_t;

    function automatic logic [REG_W-1:0] pack_state(input irq_state_t s);
        logic [REG_W-1:0] r;
        r           = '0;
        r[MODE_BIT] = s.mode;
        r[AF_BIT]   = s.alarm_flag;
        r[TF_BIT]   = s.timer_flag;
        r[AIE_BIT]  = s.alarm_en;
        r[TIE_BIT]  = s.timer_en;
        return r;
    endfunction

    function automatic logic sticky_next(input logic cur, input logic set_evt,
                                         input logic wr, input logic wr_bit);
        if (set_evt)
            return 1'b1;
        else if (wr)
            return cur & wr_bit;
        else
            return cur;
    endfunction

endpackage

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_ctl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic wr_en,
    input  logic wr_bit,
    output logic q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= 1'b0;
        else
            q <= sticky_next(q, set_evt, wr_en, wr_bit);
    end

    // R2 R3 R6
    sticky_set_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> q);

    // R4
    and_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_bit && !set_evt) |=> !q);

    // R2 R3
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_evt && (!wr_en || wr_bit)) |=> (q == $past(q)));

endmodule

// File: rtl/irq_ctl_regs.sv
module irq_ctl_regs
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    input  logic             alarm_evt,
    input  logic             timer_evt,
    output irq_state_t       st
);

    logic [NUM_FLAGS-1:0] set_vec;
    logic [NUM_FLAGS-1:0] wbit_vec;
    logic [NUM_FLAGS-1:0] flag_q;
    tmr_mode_e            mode_q;
    logic                 aie_q;
    logic                 tie_q;
    logic                 unused_hi_bits;

    assign unused_hi_bits = ^wr_data[REG_W-1:USED_W];

    always_comb begin
        set_vec              = '0;
        wbit_vec             = '0;
        set_vec[FLAG_TIMER]  = timer_evt;
        set_vec[FLAG_ALARM]  = alarm_evt;
        wbit_vec[FLAG_TIMER] = wr_data[TF_BIT];
        wbit_vec[FLAG_ALARM] = wr_data[AF_BIT];
    end

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        irq_flag_cell u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_evt (set_vec[i]),
            .wr_en   (wr_en),
            .wr_bit  (wbit_vec[i]),
            .q       (flag_q[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_q <= TMR_LEVEL;
            aie_q  <= 1'b0;
            tie_q  <= 1'b0;
        end else if (wr_en) begin
            mode_q <= tmr_mode_e'(wr_data[MODE_BIT]);
            aie_q  <= wr_data[AIE_BIT];
            tie_q  <= wr_data[TIE_BIT];
        end
    end

    always_comb begin
        st.mode       = mode_q;
        st.alarm_flag = flag_q[FLAG_ALARM];
        st.timer_flag = flag_q[FLAG_TIMER];
        st.alarm_en   = aie_q;
        st.timer_en   = tie_q;
    end

    // R5
    cfg_load_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (st.alarm_en == $past(wr_data[AIE_BIT]) &&
                   st.timer_en == $past(wr_data[TIE_BIT]) &&
                   st.mode == tmr_mode_e'($past(wr_data[MODE_BIT]))));

    // R5
    cfg_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> ($stable(st.alarm_en) && $stable(st.timer_en) && $stable(st.mode)));

endmodule

// File: rtl/irq_req_combiner.sv
module irq_req_combiner
    import irq_ctl_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  irq_state_t st,
    input  logic       timer_pulse,
    output logic       irq_req
);

    irq_terms_t terms;

    always_comb begin
        terms.alarm_term = st.alarm_flag & st.alarm_en;
        unique case (st.mode)
            TMR_PULSE: terms.timer_term = timer_pulse & st.timer_en;
            default:   terms.timer_term = st.timer_flag & st.timer_en;
        endcase
        irq_req = terms.alarm_term | terms.timer_term;
    end

    // R10
    released_chk: assert property (@(posedge clk) disable iff (rst)
        (!st.alarm_en && !st.timer_en) |-> !irq_req);

    // R9
    alarm_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (st.alarm_flag && st.alarm_en) |-> irq_req);

    // R7
    level_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (st.mode == TMR_LEVEL && st.timer_flag && st.timer_en) |-> irq_req);

    // R8
    pulse_mask_chk: assert property (@(posedge clk) disable iff (rst)
        (st.mode == TMR_PULSE && !timer_pulse && !(st.alarm_flag && st.alarm_en)) |-> !irq_req);

endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             alarm_evt,
    input  logic             timer_evt,
    input  logic             timer_pulse,
    output logic             irq_oe,
    output logic             irq_o
);

    irq_state_t st;
    logic       irq_req;

    irq_ctl_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .alarm_evt (alarm_evt),
        .timer_evt (timer_evt),
        .st        (st)
    );

    irq_req_combiner u_comb (
        .clk         (clk),
        .rst         (rst),
        .st          (st),
        .timer_pulse (timer_pulse),
        .irq_req     (irq_req)
    );

    assign rd_data = pack_state(st);
    assign irq_oe  = irq_req;
    assign irq_o   = 1'b0;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (rd_data == '0));

endmodule

// File: tb/irq_flag_unit_tb.sv
`timescale 1ns/1ps
module irq_flag_unit_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       alarm_evt = 1'b0;
    logic       timer_evt = 1'b0;
    logic       timer_pulse = 1'b0;
    logic       irq_oe;
    logic       irq_o;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    // reference state
    bit m_af, m_tf, m_aie, m_tie, m_mode;

    always #10 clk = ~clk;

    irq_flag_unit u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .alarm_evt(alarm_evt), .timer_evt(timer_evt), .timer_pulse(timer_pulse),
        .irq_oe(irq_oe), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_rd();
        return {3'b000, m_mode, m_af, m_tf, m_aie, m_tie};
    endfunction

    function automatic logic exp_irq(input logic p);
        bit tterm;
        tterm = m_mode ? p : m_tf;
        return (m_af & m_aie) | (tterm & m_tie);
    endfunction

    task automatic compare(input string tag);
        logic [7:0] er;
        logic       ei;
        er = exp_rd();
        ei = exp_irq(timer_pulse);
        n_vec++;
        if (rd_data !== er) begin
            n_fail++;
            $display("FAIL %s rd_data actual=%02h expected=%02h", tag, rd_data, er);
        end
        if (irq_oe !== ei) begin
            n_fail++;
            $display("FAIL %s irq_oe actual=%b expected=%b", tag, irq_oe, ei);
        end
        if (irq_o !== 1'b0) begin
            n_fail++;
            $display("FAIL R10 irq_o actual=%b expected=0", irq_o);
        end
    endtask

    task automatic step(input logic w, input logic [7:0] d, input logic a,
                        input logic t, input logic p, input string tag);
        @(negedge clk);
        wr_en = w; wr_data = d; alarm_evt = a; timer_evt = t; timer_pulse = p;
        #2;
        compare(tag);
        @(posedge clk);
        if (w) begin
            m_mode = d[4]; m_aie = d[1]; m_tie = d[0];
            m_af = m_af & d[3];
            m_tf = m_tf & d[2];
        end
        if (a) m_af = 1'b1;
        if (t) m_tf = 1'b1;
    endtask

    task automatic idle(input logic p, input string tag);
        step(1'b0, 8'h00, 1'b0, 1'b0, p, tag);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        m_af = 0; m_tf = 0; m_aie = 0; m_tie = 0; m_mode = 0;
        rst = 1'b1;
        wr_en = 1'b1; wr_data = 8'hFF; alarm_evt = 1'b1; timer_evt = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0; wr_data = 8'h00; alarm_evt = 1'b0; timer_evt = 1'b0;
        #2 compare("R1 reset");

        // R2: alarm event sets bit 3, holds
        step(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, "R2 set");
        idle(1'b0, "R2 hold");
        idle(1'b0, "R2 hold");
        // R3: timer event sets bit 2
        step(1'b0, 8'h00, 1'b0, 1'b1, 1'b0, "R3 set");
        idle(1'b0, "R3 hold");
        // R5: enables load, upper bits ignored
        step(1'b1, 8'hEF, 1'b0, 1'b0, 1'b0, "R5 write");
        idle(1'b0, "R5 readback");
        idle(1'b0, "R7 level both");
        // R4: clear alarm only, timer stays
        step(1'b1, 8'h07, 1'b0, 1'b0, 1'b0, "R4 clear alarm");
        idle(1'b0, "R4 timer kept");
        // R7: level mode timer-only interrupt
        idle(1'b0, "R7 timer level");
        // R6: set wins over clear
        step(1'b1, 8'h03, 1'b1, 1'b1, 1'b0, "R6 coincide");
        idle(1'b0, "R6 result");
        // R10: both enables off
        step(1'b1, 8'h0C, 1'b0, 1'b0, 1'b0, "R10 disable");
        idle(1'b1, "R10 released");
        // R8: pulse mode, timer enable only, alarm cleared
        step(1'b1, 8'h15, 1'b0, 1'b0, 1'b0, "R8 pulse mode");
        idle(1'b0, "R8 no pulse");
        idle(1'b1, "R8 pulse");
        idle(1'b0, "R8 no pulse");
        // R9: alarm enabled in pulse mode stays asserted
        step(1'b1, 8'h17, 1'b1, 1'b0, 1'b0, "R9 arm");
        idle(1'b0, "R9 steady");
        idle(1'b1, "R9 steady");
        idle(1'b0, "R9 steady");
        // R4: clear both
        step(1'b1, 8'h00, 1'b0, 1'b0, 1'b0, "R4 clear both");
        idle(1'b0, "R4 cleared");

        // random mix: R2 R3 R4 R5 R6 R7 R8 R9 R10
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 4) == 0, 8'($urandom), ($urandom % 5) == 0,
                 ($urandom % 5) == 0, $urandom % 2, "R4-mix");
        end

        // R1: reset in the middle of activity
        @(negedge clk);
        rst = 1'b1; wr_en = 1'b0; alarm_evt = 1'b0; timer_evt = 1'b0; timer_pulse = 1'b0;
        @(posedge clk);
        m_af = 0; m_tf = 0; m_aie = 0; m_tie = 0; m_mode = 0;
        @(negedge clk);
        rst = 1'b0;
        #2 compare("R1 re-reset");

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end

endmodule